// File: doc/BRIEF.md
# Configuration access router with bridge

This block accepts configuration reads and writes carrying a 24-bit address. It sends each access to the register file of the device that the address selects. Bus 0 holds a set of local endpoint devices and one bridge device. The bridge owns a secondary bus that holds a second set of endpoints. Software programs the number of that secondary bus by writing the bridge's own header. From then on, any access that carries that bus number goes to the secondary endpoints.

Endpoint positions on each bus are fixed at elaboration. They follow an automatic placement rule: start at a minimum device/function number and step by 8, taking each free position in turn. On bus 0 the bridge's position is skipped. An access that finds no device is absorbed without effect. On a read, such an access returns all ones across the requested width.

Every accepted request is answered one cycle later by a done pulse, which carries the read data.

Top module: `cfg_access_router`

## Requirements
- R1: Each request accepted with `req_valid` high at a clock edge gives exactly one `rsp_done` pulse, one cycle wide, after that edge. `rsp_rdata` is valid while `rsp_done` is high, and it reads zero for a write. After reset, `rsp_done` is low.
- R2: Address fields are as follows. The bus number is in bits [23:16]. The device/function number is in bits [15:8]: slot in [15:11], function in [10:8]. The register offset is in bits [7:0]. A device answers only to its exact device/function number, so a nonzero function field on a populated slot misses.
- R3: The length code `req_len` selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. Byte k of the data maps to offset+k, little-endian. Read bytes above the width return 0. On a present device, bytes at or past the end of its register file read 0, and writes to them are dropped.
- R4: Bus 0 endpoint i sits at the i-th position counted from PRI_DEVFN_MIN in steps of 8, skipping the bridge position. With defaults this gives 0x00, 0x08 and 0x18. Each endpoint's vendor ID at offset 0x00 is 0xC0DE, and its device ID at offset 0x02 is 0x0100+i. Bytes 0x00 to 0x03 are read-only. All other bytes reset to 0 and are writable.
- R5: The bridge sits at devfn 0x10 on bus 0, with vendor ID 0xC0DE and device ID 0xB000. Its header resets to: command 0x06 (offset 0x04), status 0xA0 (offset 0x06), class 0x0604 (offsets 0x0A to 0x0B), latency timer 0x10 (offset 0x0D), header type 0x81 (offset 0x0E), secondary status 0xA0 (offset 0x1E). All other bytes reset to 0. Bytes 0x00 to 0x03, 0x08 to 0x0B and 0x0E are read-only.
- R6: The secondary bus number is header byte 0x19 of the bridge, and it resets to 0. Any write to the bridge whose bytes include offset 0x19 updates it. This covers a 1-byte write at 0x19 (data bits [7:0]) and a 2- or 4-byte write at 0x18 (data bits [15:8]). The new number routes the very next access.
- R7: An access whose bus number is nonzero and equals the secondary bus number goes to secondary endpoint i. That endpoint sits at SEC_DEVFN_MIN + 8*i (0x00 and 0x08 by default), with vendor ID 0xC0DE and device ID 0x0200+i. Bus 0 always reaches the local devices, even when the secondary number is 0.
- R8: A read to an unknown bus or an absent device returns ones in the requested width and zeros above: 0x000000FF, 0x0000FFFF or 0xFFFFFFFF.
- R9: A write to an unknown bus or an absent device changes no register in any device and leaves the secondary bus number unchanged.
- R10: Writable bytes keep written values, and a read does not alter any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe, one access per cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Bus, device/function and offset |
| req_len | input | 2 | Width code: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits [7:0] |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |

## Verification
The bench builds the block with its default parameters: three bus-0 endpoints, the bridge at devfn 0x10, two secondary endpoints and 64-byte register files. Because the bridge sits at 0x10, the third local endpoint lands at 0x18, which exercises the skip in the placement rule. The 64-byte file size puts the end-of-file clipping within reach of an access at offset 0x3E. The secondary bus number is moved several times, through both the single-byte and the wider write forms. After each move the bench accesses the old and new bus numbers back to back, and it confirms that writes to nonexistent targets leave every device untouched.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    localparam int IDX_W = 4;
    localparam logic [7:0] SECBUS_OFF = 8'h19;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_PRI    = 2'd1,
        TGT_BRIDGE = 2'd2,
        TGT_SEC    = 2'd3
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } route_t;

    typedef struct packed {
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] off;
    } cfg_addr_t;

    function automatic logic [2:0] len_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] ones_for_len(input logic [1:0] code);
        case (code)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // i-th free position from min_devfn in steps of 8, optionally skipping one
    function automatic logic [7:0] auto_devfn(input int min_devfn, input bit skip_en,
                                              input int skip_devfn, input int idx);
        int n;
        int d;
        bit found;
        logic [7:0] res;
        n = 0;
        found = 1'b0;
        res = 8'hFF;
        for (int s = 0; s < 32; s++) begin
            d = min_devfn + 8 * s;
            if (!found && d <= 255 && !(skip_en && d == skip_devfn)) begin
                if (n == idx) begin
                    res = 8'(d);
                    found = 1'b1;
                end
                n++;
            end
        end
        return res;
    endfunction

    function automatic logic [7:0] hdr_default(input bit bridge, input logic [15:0] vid,
                                               input logic [15:0] did, input int i);
        case (i)
            0: return vid[7:0];
            1: return vid[15:8];
            2: return did[7:0];
            3: return did[15:8];
            default: ;
        endcase
        if (bridge) begin
            case (i)
                4:  return 8'h06;
                6:  return 8'hA0;
                10: return 8'h04;
                11: return 8'h06;
                13: return 8'h10;
                14: return 8'h81;
                30: return 8'hA0;
                default: ;
            endcase
        end
        return 8'h00;
    endfunction

    function automatic bit hdr_readonly(input bit bridge, input int i);
        if (i < 4) return 1'b1;
        if (bridge && ((i >= 8 && i <= 11) || i == 14)) return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
    import cfg_router_pkg::*;
#(
    parameter int PRI_EPS       = 3,
    parameter int SEC_EPS       = 2,
    parameter int BRIDGE_DEVFN  = 16,
    parameter int PRI_DEVFN_MIN = 0,
    parameter int SEC_DEVFN_MIN = 0
) (
    input  cfg_addr_t  addr,
    input  logic [7:0] sec_bus,
    output route_t     rt
);

    always_comb begin
        rt.kind = TGT_NONE;
        rt.idx  = '0;
        if (addr.bus == 8'h00) begin
            if (addr.devfn == 8'(BRIDGE_DEVFN)) begin
                rt.kind = TGT_BRIDGE;
            end
            for (int i = 0; i < PRI_EPS; i++) begin
                if (addr.devfn == auto_devfn(PRI_DEVFN_MIN, 1'b1, BRIDGE_DEVFN, i)) begin
                    rt.kind = TGT_PRI;
                    rt.idx  = IDX_W'(i);
                end
            end
        end else if (addr.bus == sec_bus) begin
            for (int i = 0; i < SEC_EPS; i++) begin
                if (addr.devfn == auto_devfn(SEC_DEVFN_MIN, 1'b0, 0, i)) begin
                    rt.kind = TGT_SEC;
                    rt.idx  = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_router_pkg::*;
#(
    parameter int          RF_BYTES  = 64,
    parameter bit          IS_BRIDGE = 1'b0,
    parameter logic [15:0] VID       = 16'hC0DE,
    parameter logic [15:0] DID       = 16'h0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        wr,
    input  logic [7:0]  off,
    input  logic [1:0]  len,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam int IW = $clog2(RF_BYTES);

    logic [7:0] mem [RF_BYTES];
    logic [8:0] lane_a [4];
    logic [3:0] lane_in;
    logic [3:0] lane_we;
    logic [2:0] nb;

    always_comb begin
        nb = len_bytes(len);
        for (int k = 0; k < 4; k++) begin
            lane_a[k]  = {1'b0, off} + 9'(k);
            lane_in[k] = (3'(k) < nb) && (lane_a[k] < 9'(RF_BYTES));
            lane_we[k] = sel && wr && lane_in[k] && !hdr_readonly(IS_BRIDGE, int'(lane_a[k]));
            rdata[8*k +: 8] = lane_in[k] ? mem[lane_a[k][IW-1:0]] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_BYTES; i++) begin
                mem[i] <= hdr_default(IS_BRIDGE, VID, DID, i);
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                if (lane_we[k]) begin
                    mem[lane_a[k][IW-1:0]] <= wdata[8*k +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfg_router_pkg::*;
#(
    parameter int          PRI_EPS       = 3,
    parameter int          SEC_EPS       = 2,
    parameter int          BRIDGE_DEVFN  = 16,
    parameter int          PRI_DEVFN_MIN = 0,
    parameter int          SEC_DEVFN_MIN = 0,
    parameter int          RF_BYTES      = 64,
    parameter logic [15:0] VENDOR        = 16'hC0DE,
    parameter logic [15:0] PRI_DID_BASE  = 16'h0100,
    parameter logic [15:0] SEC_DID_BASE  = 16'h0200,
    parameter logic [15:0] BRIDGE_DID    = 16'hB000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [23:0] req_addr,
    input  logic [1:0]  req_len,
    input  logic [31:0] req_wdata,
    output logic        rsp_done,
    output logic [31:0] rsp_rdata
);

    cfg_addr_t   a;
    route_t      rt;
    logic [7:0]  sec_bus;
    logic [7:0]  sec_nxt;
    logic        route_hit;
    logic        bridge_wr;
    logic [2:0]  nb;
    logic [31:0] rd_mux;
    logic [31:0] br_rd;
    logic [31:0] pri_rd [PRI_EPS];
    logic [31:0] sec_rd [SEC_EPS];

    assign a         = cfg_addr_t'(req_addr);
    assign nb        = len_bytes(req_len);
    assign route_hit = (rt.kind != TGT_NONE);
    assign bridge_wr = req_valid && req_write && (rt.kind == TGT_BRIDGE);

    cfg_route_decode #(
        .PRI_EPS      (PRI_EPS),
        .SEC_EPS      (SEC_EPS),
        .BRIDGE_DEVFN (BRIDGE_DEVFN),
        .PRI_DEVFN_MIN(PRI_DEVFN_MIN),
        .SEC_DEVFN_MIN(SEC_DEVFN_MIN)
    ) u_decode (
        .addr   (a),
        .sec_bus(sec_bus),
        .rt     (rt)
    );

    cfg_regfile #(
        .RF_BYTES (RF_BYTES),
        .IS_BRIDGE(1'b1),
        .VID      (VENDOR),
        .DID      (BRIDGE_DID)
    ) u_bridge (
        .clk  (clk),
        .rst  (rst),
        .sel  (req_valid && rt.kind == TGT_BRIDGE),
        .wr   (req_write),
        .off  (a.off),
        .len  (req_len),
        .wdata(req_wdata),
        .rdata(br_rd)
    );

    for (genvar g = 0; g < PRI_EPS; g++) begin : gen_pri
        cfg_regfile #(
            .RF_BYTES (RF_BYTES),
            .IS_BRIDGE(1'b0),
            .VID      (VENDOR),
            .DID      (PRI_DID_BASE + 16'(g))
        ) u_ep (
            .clk  (clk),
            .rst  (rst),
            .sel  (req_valid && rt.kind == TGT_PRI && rt.idx == IDX_W'(g)),
            .wr   (req_write),
            .off  (a.off),
            .len  (req_len),
            .wdata(req_wdata),
            .rdata(pri_rd[g])
        );
    end

    for (genvar g = 0; g < SEC_EPS; g++) begin : gen_sec
        cfg_regfile #(
            .RF_BYTES (RF_BYTES),
            .IS_BRIDGE(1'b0),
            .VID      (VENDOR),
            .DID      (SEC_DID_BASE + 16'(g))
        ) u_ep (
            .clk  (clk),
            .rst  (rst),
            .sel  (req_valid && rt.kind == TGT_SEC && rt.idx == IDX_W'(g)),
            .wr   (req_write),
            .off  (a.off),
            .len  (req_len),
            .wdata(req_wdata),
            .rdata(sec_rd[g])
        );
    end

    // Secondary bus number follows whatever bridge write covers header byte 0x19
    always_comb begin
        sec_nxt = sec_bus;
        for (int k = 0; k < 4; k++) begin
            if (bridge_wr && (3'(k) < nb) && (({1'b0, a.off} + 9'(k)) == {1'b0, SECBUS_OFF})) begin
                sec_nxt = req_wdata[8*k +: 8];
            end
        end
    end

    always_comb begin
        rd_mux = ones_for_len(req_len);
        case (rt.kind)
            TGT_BRIDGE: rd_mux = br_rd;
            TGT_PRI: begin
                for (int i = 0; i < PRI_EPS; i++) begin
                    if (rt.idx == IDX_W'(i)) rd_mux = pri_rd[i];
                end
            end
            TGT_SEC: begin
                for (int i = 0; i < SEC_EPS; i++) begin
                    if (rt.idx == IDX_W'(i)) rd_mux = sec_rd[i];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_bus   <= 8'h00;
            rsp_done  <= 1'b0;
            rsp_rdata <= 32'h0;
        end else begin
            sec_bus   <= sec_nxt;
            rsp_done  <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'h0;
        end
    end

endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk
    import cfg_router_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_len,
    input logic        rsp_done,
    input logic [31:0] rsp_rdata,
    input logic        hit,
    input logic        to_bridge,
    input logic [7:0]  sec_bus
);

    // R1: one done pulse per accepted request, one cycle later
    a_r1_done_follows_req: assert property (@(posedge clk) disable iff (rst)
        rsp_done == $past(req_valid));

    // R1: writes answer with zero data
    a_r1_write_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && $past(req_write)) |-> (rsp_rdata == 32'h0));

    // R1: quiet output after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !rsp_done);

    // R3: single-byte reads leave upper lanes zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !$past(req_write) && $past(req_len) == 2'd0) |-> (rsp_rdata[31:8] == 24'h0));

    // R8: a read miss returns ones in the requested width
    a_r8_miss_ones: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !$past(req_write) && !$past(hit)) |-> (rsp_rdata == ones_for_len($past(req_len))));

    // R6 / R9: the secondary bus number moves only on a bridge write
    a_r6_secbus_by_bridge_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(sec_bus) |-> $past(req_valid && to_bridge));

endmodule

bind cfg_access_router cfg_router_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_len  (req_len),
    .rsp_done (rsp_done),
    .rsp_rdata(rsp_rdata),
    .hit      (route_hit),
    .to_bridge(bridge_wr),
    .sec_bus  (sec_bus)
);

// File: tb/tb_cfg_access_router.sv
module tb_cfg_access_router;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [23:0] addr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_router dut (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_len  (req_len),
        .req_wdata(req_wdata),
        .rsp_done (rsp_done),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: one access per call, expectation pushed to the scoreboard
    task automatic acc(input bit wr, input logic [23:0] a, input logic [1:0] len,
                       input logic [31:0] wd, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp  = wr ? 32'h0 : exp;
        e.addr = a;
        e.tag  = tag;
        sb.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_len   = len;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected done", rsp_rdata, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_rdata === e.exp, e.tag, rsp_rdata, e.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_done == 1'b0, "R1 reset done low", {31'h0, rsp_done}, 32'h0);
        check(rsp_rdata == 32'h0, "R1 reset rdata zero", rsp_rdata, 32'h0);

        // R4 local endpoints, automatic placement skipping bridge at 0x10
        acc(0, 24'h000000, 2'd2, 0, 32'h0100C0DE, "R4 ep0 id at 0x00");
        acc(0, 24'h000800, 2'd2, 0, 32'h0101C0DE, "R4 ep1 id at 0x08");
        acc(0, 24'h001800, 2'd2, 0, 32'h0102C0DE, "R4 ep2 id at 0x18");
        // R5 bridge header defaults
        acc(0, 24'h001000, 2'd2, 0, 32'hB000C0DE, "R5 bridge id");
        acc(0, 24'h001004, 2'd2, 0, 32'h00A00006, "R5 command/status");
        acc(0, 24'h001008, 2'd2, 0, 32'h06040000, "R5 class");
        acc(0, 24'h00100C, 2'd2, 0, 32'h00811000, "R5 latency/header type");
        acc(0, 24'h00101E, 2'd1, 0, 32'h000000A0, "R5 secondary status");
        acc(0, 24'h001018, 2'd2, 0, 32'h00000000, "R6 secondary bus resets 0");
        // R8 misses, R2 function field
        acc(0, 24'h050000, 2'd2, 0, 32'hFFFFFFFF, "R8 unknown bus len4");
        acc(0, 24'h050000, 2'd0, 0, 32'h000000FF, "R8 unknown bus len1");
        acc(0, 24'h002000, 2'd1, 0, 32'h0000FFFF, "R8 absent devfn len2");
        acc(0, 24'h000100, 2'd2, 0, 32'hFFFFFFFF, "R2 function 1 of slot 0 absent");
        // R6 / R7 single-byte programming at 0x19, used on the very next access
        acc(1, 24'h001019, 2'd0, 32'h00000005, 0, "R1 write response zero");
        acc(0, 24'h050000, 2'd2, 0, 32'h0200C0DE, "R7 sec ep0 on bus 5");
        acc(0, 24'h050800, 2'd2, 0, 32'h0201C0DE, "R7 sec ep1 on bus 5");
        acc(0, 24'h051000, 2'd2, 0, 32'hFFFFFFFF, "R7 sec absent devfn");
        acc(0, 24'h001018, 2'd2, 0, 32'h00000500, "R6 byte 0x19 reads 5");
        acc(0, 24'h000000, 2'd2, 0, 32'h0100C0DE, "R7 bus 0 stays local");
        // R6 two-byte write at 0x18
        acc(1, 24'h001018, 2'd1, 32'h00000700, 0, "R6 write 0x18 len2");
        acc(0, 24'h050000, 2'd2, 0, 32'hFFFFFFFF, "R6 old bus 5 now misses");
        acc(0, 24'h070800, 2'd2, 0, 32'h0201C0DE, "R6 bus 7 reaches sec ep1");
        // R6 four-byte write at 0x18
        acc(1, 24'h001018, 2'd2, 32'h00000900, 0, "R6 write 0x18 len4");
        acc(0, 24'h090000, 2'd2, 0, 32'h0200C0DE, "R6 bus 9 reaches sec ep0");
        // R3 widths and lanes on ep1
        acc(1, 24'h000820, 2'd2, 32'hA1B2C3D4, 0, "R3 write len4");
        acc(0, 24'h000821, 2'd0, 0, 32'h000000C3, "R3 read len1 lane");
        acc(0, 24'h000822, 2'd1, 0, 32'h0000A1B2, "R3 read len2 lane");
        acc(1, 24'h000823, 2'd0, 32'h00000055, 0, "R3 write len1");
        acc(0, 24'h000820, 2'd3, 0, 32'h55B2C3D4, "R3 code 3 is 4 bytes");
        acc(0, 24'h00083E, 2'd2, 0, 32'h00000000, "R3 read past end");
        acc(1, 24'h00083E, 2'd2, 32'h11223344, 0, "R3 write past end");
        acc(0, 24'h00083E, 2'd2, 0, 32'h00003344, "R3 clipped write");
        acc(1, 24'h000800, 2'd2, 32'hFFFFFFFF, 0, "R4 write id bytes");
        acc(0, 24'h000800, 2'd2, 0, 32'h0101C0DE, "R4 id read-only");
        // R9 writes that miss
        acc(1, 24'h002020, 2'd2, 32'hDEADBEEF, 0, "R9 write absent devfn");
        acc(1, 24'h330020, 2'd2, 32'hDEADBEEF, 0, "R9 write unknown bus");
        acc(1, 24'h331019, 2'd0, 32'h00000044, 0, "R9 write unknown bus 0x19");
        acc(0, 24'h000020, 2'd2, 0, 32'h00000000, "R9 ep0 untouched");
        acc(0, 24'h001820, 2'd2, 0, 32'h00000000, "R9 ep2 untouched");
        acc(0, 24'h001020, 2'd2, 0, 32'h00000000, "R9 bridge untouched");
        acc(0, 24'h090020, 2'd2, 0, 32'h00000000, "R9 sec ep0 untouched");
        acc(0, 24'h090800, 2'd2, 0, 32'h0201C0DE, "R9 secondary bus kept");
        // R10 writable bridge bytes, read-only class, reads without effect
        acc(1, 24'h001004, 2'd0, 32'h00000007, 0, "R10 write command");
        acc(0, 24'h001004, 2'd1, 0, 32'h00000007, "R10 command kept");
        acc(1, 24'h00100A, 2'd1, 32'h0000FFFF, 0, "R5 write class");
        acc(0, 24'h00100A, 2'd1, 0, 32'h00000604, "R5 class read-only");
        acc(0, 24'h000820, 2'd2, 0, 32'h55B2C3D4, "R10 value survives reads");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 all responses seen", 32'(sb.size()), 32'h0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule